// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Driver

This block scans a five-digit multiplexed seven-segment display. It takes five 6-bit character codes, one per digit, and one decimal-point flag per digit. A free-running prescaler moves a digit index through 0..4 at a steady rate. Index 0 is the leftmost, most significant digit. For the selected digit the block looks up the segment pattern of its character and drives the enable pattern for that digit. Both sets of outputs follow a parameter that selects common-cathode or common-anode polarity.

Four digit-enable lines serve five digits. Digits 0..3 each have their own line, in an irregular line order. Digit 4 is the one that lights when none of the four lines is active. For this reason, at every digit change the block holds the enables inactive for one clock and also turns every segment off. After reset the block lights every segment, the decimal point included, for a lamp-test period while the scan runs. A blank input turns all segments off at once for power saving and leaves the scan running. The alphabet covers the digits 0..9, hex A..F and the letters and symbols needed for menu text.

The controller has four states. ST_LAMP_ON drives the lamp-test pattern. ST_LAMP_GAP is the one-clock gap during the lamp test. ST_SHOW drives a character. ST_GAP is the one-clock gap in normal operation. The transitions are:
- ST_LAMP_ON to ST_LAMP_GAP on a scan tick.
- ST_LAMP_ON to ST_SHOW when the lamp period ends.
- ST_LAMP_ON to ST_GAP when a tick and the end of the lamp period coincide.
- ST_LAMP_GAP back to ST_LAMP_ON, or to ST_SHOW once the lamp period ends.
- ST_SHOW to ST_GAP on a tick.
- ST_GAP back to ST_SHOW.

Top module: `seg_mux_drv`

## Requirements
- R1: After reset, for the first LAMP_CYCLES clock edges (CLK_HZ/1000*LAMP_MS), every non-gap cycle drives all eight segment bits on (raw 0xFF) regardless of the codes. From edge LAMP_CYCLES onward the characters are shown.
- R2: The digit index starts at 0 and advances by one every 2^PRESC_W clocks, wrapping from 4 to 0. After edge n it equals (n / 2^PRESC_W) mod 5.
- R3: Common cathode (COMMON_ANODE=0): en_o[3:0] is 4'b0111 for digit 0, 4'b1011 for digit 1, 4'b1110 for digit 2 and 4'b1101 for digit 3. Digit 4 is selected by 4'b1111, with all lines inactive. At most one line is active at a time.
- R4: Common anode (COMMON_ANODE=1): en_o is the bitwise inverse of the common-cathode pattern (4'b1000, 4'b0100, 4'b0001, 4'b0010 and 4'b0000). seg_o is the bitwise inverse of the raw pattern.
- R5: Raw segment bits are A=0x40, B=0x80, C=0x04, D=0x01, E=0x08, F=0x10, G=0x20 and DP=0x02. Digit d's code is char_i[6*d+5:6*d]. Examples: code 0=0xDD, 1=0x84, 8=0xFD, 9=0xF5, 10 (A)=0xFC, 21 (P)=0xF8, 22 (r)=0x28, 35 (=)=0x21.
- R6: Code 19 gives raw 0x00 and code 20 gives raw 0xFF. Codes 36..63 give raw 0x00.
- R7: A set dp_i[d] ORs 0x02 into the raw pattern of digit d. For example, code 0 with its point set gives 0xDF.
- R8: While blank_i is high, seg_o sits at its off level in the same cycle, and the enables keep scanning.
- R9: On the clock after each index change (edges n>0 with n mod 2^PRESC_W = 0), the enables are all inactive and the segments are off, for exactly one clock.
- R10: The glyph for 6 includes segment A (raw 0x7D) and the glyph for 9 includes segment D (raw 0xF5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blank_i | input | 1 | Force all segments off |
| char_i | input | 30 | Five 6-bit character codes, digit 0 in bits 5:0 |
| dp_i | input | 5 | Decimal-point flag per digit |
| seg_o | output | 8 | Segment lines, polarity per COMMON_ANODE |
| en_o | output | 4 | Digit-enable lines, polarity per COMMON_ANODE |

## Verification
State and digit index change only at clock edges, and both outputs are combinational from that state and from the inputs. A change on blank_i, char_i or dp_i therefore shows in the same cycle, while an index step shows right after edge n with n mod 2^PRESC_W = 0, and the lamp pattern ends right after edge LAMP_CYCLES. The bench counts the edges since reset is released and samples on falling edges at chosen edge numbers. Expected index, gap and lamp status are derived from that number. Input changes are made on a falling edge and checked 1 ns later, before the next rising edge.

// File: rtl/seg_mux_pkg.sv
package seg_mux_pkg;

    localparam int DIGITS = 5;
    localparam int CODE_W = 6;
    localparam int EN_W   = 4;
    localparam int IDX_W  = $clog2(DIGITS);

    localparam logic [7:0] S_A  = 8'h40;
    localparam logic [7:0] S_B  = 8'h80;
    localparam logic [7:0] S_C  = 8'h04;
    localparam logic [7:0] S_D  = 8'h01;
    localparam logic [7:0] S_E  = 8'h08;
    localparam logic [7:0] S_F  = 8'h10;
    localparam logic [7:0] S_G  = 8'h20;
    localparam logic [7:0] S_DP = 8'h02;

    typedef enum logic [1:0] {
        ST_LAMP_ON,
        ST_LAMP_GAP,
        ST_SHOW,
        ST_GAP
    } scan_state_t;

    // enable line owned by each digit; digit 4 owns none
    function automatic logic [EN_W-1:0] line_of(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    line_of = 4'b1000;
            3'd1:    line_of = 4'b0100;
            3'd2:    line_of = 4'b0001;
            3'd3:    line_of = 4'b0010;
            default: line_of = 4'b0000;
        endcase
    endfunction

    // active-high segment pattern for a character code
    function automatic logic [7:0] glyph(input logic [CODE_W-1:0] code);
        case (code)
            6'd0:  glyph = S_A | S_B | S_C | S_D | S_E | S_F;
            6'd1:  glyph = S_B | S_C;
            6'd2:  glyph = S_A | S_B | S_D | S_E | S_G;
            6'd3:  glyph = S_A | S_B | S_C | S_D | S_G;
            6'd4:  glyph = S_B | S_C | S_F | S_G;
            6'd5:  glyph = S_A | S_C | S_D | S_F | S_G;
            6'd6:  glyph = S_A | S_C | S_D | S_E | S_F | S_G;
            6'd7:  glyph = S_A | S_B | S_C;
            6'd8:  glyph = S_A | S_B | S_C | S_D | S_E | S_F | S_G;
            6'd9:  glyph = S_A | S_B | S_C | S_D | S_F | S_G;
            6'd10: glyph = S_A | S_B | S_C | S_E | S_F | S_G;
            6'd11: glyph = S_C | S_D | S_E | S_F | S_G;
            6'd12: glyph = S_D | S_E | S_G;
            6'd13: glyph = S_B | S_C | S_D | S_E | S_G;
            6'd14: glyph = S_A | S_D | S_E | S_F | S_G;
            6'd15: glyph = S_A | S_E | S_F | S_G;
            6'd16: glyph = S_A | S_C | S_D | S_E | S_F;
            6'd17: glyph = S_B | S_C | S_E | S_F | S_G;
            6'd18: glyph = S_E;
            6'd19: glyph = 8'h00;
            6'd20: glyph = 8'hFF;
            6'd21: glyph = S_A | S_B | S_E | S_F | S_G;
            6'd22: glyph = S_E | S_G;
            6'd23: glyph = S_C | S_D | S_E | S_G;
            6'd24: glyph = S_A | S_B | S_C | S_F | S_G;
            6'd25: glyph = S_C | S_D | S_E;
            6'd26: glyph = S_D | S_E | S_F | S_G;
            6'd27: glyph = S_A | S_C | S_D | S_F | S_G;
            6'd28: glyph = S_A | S_B | S_D | S_E | S_G;
            6'd29: glyph = S_E | S_F;
            6'd30: glyph = S_B | S_C | S_D;
            6'd31: glyph = S_D | S_E | S_F | S_G;
            6'd32: glyph = S_D | S_E | S_F;
            6'd33: glyph = S_A | S_B | S_C | S_E | S_F;
            6'd34: glyph = S_C | S_D | S_E | S_F;
            6'd35: glyph = S_D | S_G;
            default: glyph = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/seg_scan_timer.sv
module seg_scan_timer #(
    parameter int PRESC_W     = 16,
    parameter int LAMP_CYCLES = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o,
    output logic lamp_end_o
);
    localparam int LAMP_W = $clog2(LAMP_CYCLES + 1);
    localparam logic [LAMP_W-1:0] LAMP_LAST = LAMP_W'(LAMP_CYCLES - 1);

    logic [PRESC_W-1:0] presc_q;
    logic [LAMP_W-1:0]  lamp_q;
    logic               lamp_done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
        end else begin
            presc_q <= presc_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lamp_q      <= '0;
            lamp_done_q <= 1'b0;
        end else if (!lamp_done_q) begin
            if (lamp_q == LAMP_LAST) begin
                lamp_done_q <= 1'b1;
            end else begin
                lamp_q <= lamp_q + 1'b1;
            end
        end
    end

    assign tick_o     = &presc_q;
    assign lamp_end_o = !lamp_done_q && (lamp_q == LAMP_LAST);

    // R1: the lamp test ends once and never restarts
    p_lamp_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_done_q |=> (lamp_done_q && !lamp_end_o));

    // R2: a tick is followed by a tick-free cycle
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/seg_digit_en.sv
module seg_digit_en
    import seg_mux_pkg::*;
#(
    parameter bit COMMON_ANODE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             gap_i,
    output logic [EN_W-1:0]  en_o
);
    logic [EN_W-1:0] act;

    always_comb begin
        act = gap_i ? '0 : line_of(idx_i);
    end

    generate
        if (COMMON_ANODE) begin : g_ca
            assign en_o = act;
        end else begin : g_cc
            assign en_o = ~act;
        end
    endgenerate

    // R3: at most one enable line active, seen at the pins
    p_one_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(COMMON_ANODE ? en_o : ~en_o));

    // R9: no line active during a gap
    p_gap_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gap_i |-> (en_o == (COMMON_ANODE ? 4'b0000 : 4'b1111)));

endmodule

// File: rtl/seg_glyph.sv
module seg_glyph
    import seg_mux_pkg::*;
#(
    parameter bit COMMON_ANODE = 1'b0
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              dp_i,
    input  logic              lamp_i,
    input  logic              dark_i,
    output logic [7:0]        seg_o
);
    logic [7:0] raw;

    always_comb begin
        if (dark_i) begin
            raw = 8'h00;
        end else if (lamp_i) begin
            raw = 8'hFF;
        end else begin
            raw = glyph(code_i) | (dp_i ? S_DP : 8'h00);
        end
    end

    generate
        if (COMMON_ANODE) begin : g_ca
            assign seg_o = ~raw;
        end else begin : g_cc
            assign seg_o = raw;
        end
    endgenerate

endmodule

// File: rtl/seg_mux_drv.sv
module seg_mux_drv
    import seg_mux_pkg::*;
#(
    parameter bit COMMON_ANODE = 1'b0,
    parameter int PRESC_W      = 16,
    parameter int CLK_HZ       = 20_000_000,
    parameter int LAMP_MS      = 500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        blank_i,
    input  logic [29:0] char_i,
    input  logic [4:0]  dp_i,
    output logic [7:0]  seg_o,
    output logic [3:0]  en_o
);
    localparam int LAMP_CYCLES = (CLK_HZ / 1000) * LAMP_MS;
    localparam logic [7:0] SEG_OFF = COMMON_ANODE ? 8'hFF : 8'h00;
    localparam logic [7:0] SEG_ON  = COMMON_ANODE ? 8'h00 : 8'hFF;

    scan_state_t      state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             tick, lamp_end;
    logic             in_gap, in_lamp;
    logic [CODE_W-1:0] cur_code;
    logic             cur_dp;

    seg_scan_timer #(
        .PRESC_W     (PRESC_W),
        .LAMP_CYCLES (LAMP_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_o     (tick),
        .lamp_end_o (lamp_end)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LAMP_ON;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LAMP_ON: begin
                if (tick) begin
                    state_d = lamp_end ? ST_GAP : ST_LAMP_GAP;
                end else if (lamp_end) begin
                    state_d = ST_SHOW;
                end
            end
            ST_LAMP_GAP: state_d = lamp_end ? ST_SHOW : ST_LAMP_ON;
            ST_SHOW:     if (tick) state_d = ST_GAP;
            ST_GAP:      state_d = ST_SHOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (tick) begin
            idx_q <= (idx_q == IDX_W'(DIGITS - 1)) ? '0 : idx_q + 1'b1;
        end
    end

    always_comb begin
        in_gap  = 1'b0;
        in_lamp = 1'b0;
        unique case (state_q)
            ST_LAMP_ON:  in_lamp = 1'b1;
            ST_LAMP_GAP: begin in_lamp = 1'b1; in_gap = 1'b1; end
            ST_SHOW:     ;
            ST_GAP:      in_gap = 1'b1;
        endcase
    end

    assign cur_code = char_i[idx_q*CODE_W +: CODE_W];
    assign cur_dp   = dp_i[idx_q];

    seg_glyph #(
        .COMMON_ANODE (COMMON_ANODE)
    ) u_glyph (
        .code_i (cur_code),
        .dp_i   (cur_dp),
        .lamp_i (in_lamp),
        .dark_i (in_gap | blank_i),
        .seg_o  (seg_o)
    );

    seg_digit_en #(
        .COMMON_ANODE (COMMON_ANODE)
    ) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .idx_i (idx_q),
        .gap_i (in_gap),
        .en_o  (en_o)
    );

    // R2: index stays within the five digits
    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q < IDX_W'(DIGITS));

    // R9: every index change lands in a gap cycle
    p_idx_step_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q != $past(idx_q)) |-> in_gap);

    // R8: blank forces the segment off level
    p_blank_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blank_i |-> (seg_o == SEG_OFF));

    // R1: lamp test lights every segment outside gaps
    p_lamp_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_lamp && !in_gap && !blank_i) |-> (seg_o == SEG_ON));

endmodule

// File: tb/sim_seg_mux_drv.sv
module sim_seg_mux_drv;
    localparam int PW   = 5;
    localparam int STEP = 1 << PW;
    localparam int LAMP = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blank_i = 1'b0;
    logic [29:0] char_i = '0;
    logic [4:0]  dp_i = '0;
    logic [7:0]  seg_cc, seg_ca;
    logic [3:0]  en_cc, en_ca;
    int          cyc = 0;
    int          n_run = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    seg_mux_drv #(.COMMON_ANODE(1'b0), .PRESC_W(PW), .CLK_HZ(200_000), .LAMP_MS(1)) u0 (
        .clk(clk), .rst_n(rst_n), .blank_i(blank_i), .char_i(char_i),
        .dp_i(dp_i), .seg_o(seg_cc), .en_o(en_cc));

    seg_mux_drv #(.COMMON_ANODE(1'b1), .PRESC_W(PW), .CLK_HZ(200_000), .LAMP_MS(1)) u1 (
        .clk(clk), .rst_n(rst_n), .blank_i(blank_i), .char_i(char_i),
        .dp_i(dp_i), .seg_o(seg_ca), .en_o(en_ca));

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #500000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        report();
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R3 line patterns (common cathode)
    function automatic logic [3:0] en_cc_of(input int idx);
        case (idx)
            0: return 4'b0111;
            1: return 4'b1011;
            2: return 4'b1110;
            3: return 4'b1101;
            default: return 4'b1111;
        endcase
    endfunction

    // checks both polarities; R4 is the inverse relation
    task automatic chk_both(input string req, input logic [7:0] raw, input logic [3:0] en);
        chk(req, seg_cc, raw);
        chk(req, {4'h0, en_cc}, {4'h0, en});
        chk({req, "/R4"}, seg_ca, ~raw);
        chk({req, "/R4"}, {4'h0, en_ca}, {4'h0, ~en});
    endtask

    task automatic at_cycle(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    function automatic int idx_at(input int n);
        return (n / STEP) % 5;
    endfunction

    task automatic set_code(input int d, input logic [5:0] c);
        char_i[d*6 +: 6] = c;
    endtask

    task automatic t_reset;
        chk_both("R1 reset lamp", 8'hFF, 4'b0111);
    endtask

    task automatic t_lamp_scan;
        at_cycle(5);   chk_both("R1 lamp d0", 8'hFF, en_cc_of(idx_at(5)));
        at_cycle(32);  chk_both("R9 lamp gap", 8'h00, 4'b1111);
        at_cycle(40);  chk_both("R2 R3 d1", 8'hFF, en_cc_of(idx_at(40)));
        at_cycle(70);  chk_both("R3 d2", 8'hFF, 4'b1110);
        at_cycle(100); chk_both("R3 d3", 8'hFF, 4'b1101);
        at_cycle(130); chk_both("R3 d4 implicit", 8'hFF, 4'b1111);
        at_cycle(160); chk_both("R9 wrap gap", 8'h00, 4'b1111);
        at_cycle(170); chk_both("R2 wrap to d0", 8'hFF, 4'b0111);
    endtask

    task automatic t_lamp_edge;
        at_cycle(LAMP - 1); chk_both("R1 last lamp", 8'hFF, en_cc_of(1));
        at_cycle(LAMP);     chk_both("R1 first shown", 8'hF5, en_cc_of(1));
    endtask

    task automatic t_glyphs;
        at_cycle(224); chk_both("R9 gap d2", 8'h00, 4'b1111);
        at_cycle(225); chk_both("R7 dp on 0", 8'hDF, 4'b1110);
        at_cycle(260); chk_both("R5 P", 8'hF8, 4'b1101);
        at_cycle(290); chk_both("R5 equals", 8'h21, 4'b1111);
        at_cycle(330); chk_both("R10 six", 8'h7D, 4'b0111);
        chk("R10 six has A", seg_cc & 8'h40, 8'h40);
        at_cycle(335); set_code(0, 6'd9); #1;
        chk_both("R10 nine", 8'hF5, 4'b0111);
        chk("R10 nine has D", seg_cc & 8'h01, 8'h01);
        at_cycle(338); set_code(0, 6'd1); #1;  chk_both("R5 one", 8'h84, 4'b0111);
        set_code(0, 6'd10); #1;                chk_both("R5 A", 8'hFC, 4'b0111);
        set_code(0, 6'd22); #1;                chk_both("R5 r", 8'h28, 4'b0111);
        set_code(0, 6'd8);  #1;                chk_both("R5 eight", 8'hFD, 4'b0111);
    endtask

    task automatic t_codes;
        at_cycle(345); set_code(0, 6'd19); #1; chk_both("R6 blank code", 8'h00, 4'b0111);
        set_code(0, 6'd20); #1;                chk_both("R6 all code", 8'hFF, 4'b0111);
        set_code(0, 6'd40); #1;                chk_both("R6 undefined", 8'h00, 4'b0111);
    endtask

    task automatic t_blank;
        at_cycle(360);
        blank_i = 1'b1; #1;
        chk_both("R8 blank d1", 8'h00, 4'b1011);
        at_cycle(390);
        chk_both("R8 blank scan d2", 8'h00, 4'b1110);
        blank_i = 1'b0; #1;
        chk_both("R8 release", 8'hDF, 4'b1110);
    endtask

    initial begin
        set_code(0, 6'd6);
        set_code(1, 6'd9);
        set_code(2, 6'd0);
        set_code(3, 6'd21);
        set_code(4, 6'd35);
        dp_i = 5'b00100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lamp_scan();
        t_lamp_edge();
        t_glyphs();
        t_codes();
        t_blank();
        report();
    end
endmodule